// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames from a byte that the host writes into a holding register. The frame logic uses a separate shift register, so the host can write the next byte while the current frame is still on the line. An empty flag tells the host when the holding register can take a new byte. An end flag tells it when the line has gone quiet. Each flag can also raise a one-cycle interrupt pulse, gated by its own enable input.

Bit timing comes from an external baud strobe. Each strobe, one cycle wide, moves the line on by one bit. The frame format is set by static configuration inputs: 7 or 8 data bits, no extra bit or an even/odd parity bit or a host-supplied address-marker bit, and one or two stop bits. The empty flag is checked when the stop bit begins. If new data is waiting, the next frame starts right after the stop period with no idle gap. If nothing is waiting, the end flag is raised and the line rests at 1.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `empty_flag` is 1, `end_flag` is 1, and `irq_empty` and `irq_end` are 0.
- R2: A cycle with `wr_en` high stores `wr_data` and `wr_mark` in the holding register and clears both `empty_flag` and `end_flag`, starting from the next cycle.
- R3: On a strobe while idle with `empty_flag` at 0, the holding register is copied into the shift register. `empty_flag` goes to 1, and `irq_empty` pulses for one cycle if `ie_empty` is 1.
- R4: A frame is a start bit of 0, then the data bits LSB first (7 when `cfg_len7` is 1, else 8), then the optional extra bit, then the stop bits of 1. Each bit lasts exactly one strobe period.
- R5: With `cfg_par_en`=1 and `cfg_mark_en`=0, the extra bit is parity over the sent data bits. With `cfg_par_odd`=0 the total count of ones, parity included, is even; with 1 it is odd.
- R6: With `cfg_mark_en`=1, the extra bit equals the `wr_mark` value written with the data, whatever `cfg_par_en` is.
- R7: One stop bit is sent when `cfg_stop2` is 0, and two when it is 1.
- R8: If `empty_flag` is 0 when the first stop bit begins, that byte is copied (with `irq_empty` as in R3). The next start bit follows the last stop bit with no gap, and `end_flag` stays 0.
- R9: If `empty_flag` is 1 when the first stop bit begins, `end_flag` goes to 1, and `irq_end` pulses once if `ie_end` is 1. `txd` stays 1 until a later write starts a frame.
- R10: `txd` changes only on a clock edge where `baud_tick` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| wr_mark | input | 1 | Address-marker bit stored with the byte |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_mark_en | input | 1 | Append the stored marker bit in place of parity |
| cfg_stop2 | input | 1 | 1: two stop bits |
| ie_empty | input | 1 | Enable for the buffer-empty interrupt |
| ie_end | input | 1 | Enable for the transmit-end interrupt |
| baud_tick | input | 1 | One-cycle bit-rate strobe |
| txd | output | 1 | Serial line, idle at 1 |
| empty_flag | output | 1 | Holding register free |
| end_flag | output | 1 | Transmission finished, line idle |
| irq_empty | output | 1 | One-cycle buffer-empty interrupt pulse |
| irq_end | output | 1 | One-cycle transmit-end interrupt pulse |

## Verification
A wrong bit counter or shift register shows up on `txd` within one frame: a bit lands in the wrong slot, the frame has the wrong length, or the parity value is wrong. Every frame is therefore compared bit by bit, one strobe at a time, against a sequence built arithmetically in the bench for all sixteen format combinations. If the empty flag is sampled at the wrong time, the effect shows in the next frame boundary. Either an idle gap appears between chained frames, or the interrupt counts come out wrong, so chained pairs are checked for contiguity and for exact pulse counts.

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_mark,
  input  logic          cfg_len7,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_mark_en,
  input  logic          cfg_stop2,
  input  logic          ie_empty,
  input  logic          ie_end,
  input  logic          baud_tick,
  output logic          txd,
  output logic          empty_flag,
  output logic          end_flag,
  output logic          irq_empty,
  output logic          irq_end
);
  localparam int CW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_XBIT, S_STOP} st_t;

  st_t           st_q;
  logic [DW-1:0] hold_q, sh_q;
  logic [CW-1:0] cnt_q;
  logic          hold_mark_q, xbit_q, empty_q, end_q, chain_q, stop_cnt_q;
  logic          irq_e_q, irq_t_q;

  wire [CW-1:0] last    = cfg_len7 ? CW'(DW - 2) : CW'(DW - 1);
  wire          has_x   = cfg_par_en | cfg_mark_en;
  wire [DW-1:0] pmask   = cfg_len7 ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
  wire          par_bit = (^(hold_q & pmask)) ^ cfg_par_odd;
  wire          to_stop = baud_tick &&
                          ((st_q == S_DATA && cnt_q == last && !has_x) || st_q == S_XBIT);
  wire          load    = !empty_q && ((baud_tick && st_q == S_IDLE) || to_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      hold_q      <= '0;
      sh_q        <= '0;
      cnt_q       <= '0;
      hold_mark_q <= 1'b0;
      xbit_q      <= 1'b0;
      empty_q     <= 1'b1;
      end_q       <= 1'b1;
      chain_q     <= 1'b0;
      stop_cnt_q  <= 1'b0;
      irq_e_q     <= 1'b0;
      irq_t_q     <= 1'b0;
    end else begin
      irq_e_q <= load & ie_empty;
      irq_t_q <= to_stop & empty_q & ie_end;
      if (baud_tick) begin
        case (st_q)
          S_IDLE:  if (!empty_q) st_q <= S_START;
          S_START: begin st_q <= S_DATA; cnt_q <= '0; end
          S_DATA:
            if (cnt_q == last) st_q <= has_x ? S_XBIT : S_STOP;
            else begin
              cnt_q <= cnt_q + 1'b1;
              sh_q  <= sh_q >> 1;
            end
          S_XBIT:  st_q <= S_STOP;
          S_STOP:
            if (cfg_stop2 && !stop_cnt_q) stop_cnt_q <= 1'b1;
            else st_q <= chain_q ? S_START : S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
      if (to_stop) begin
        stop_cnt_q <= 1'b0;
        chain_q    <= !empty_q;
        if (empty_q) end_q <= 1'b1;
      end
      if (load) begin
        sh_q    <= hold_q;
        xbit_q  <= cfg_mark_en ? hold_mark_q : par_bit;
        empty_q <= 1'b1;
      end
      if (wr_en) begin
        hold_q      <= wr_data;
        hold_mark_q <= wr_mark;
        empty_q     <= 1'b0;
        end_q       <= 1'b0;
      end
    end
  end

  always_comb begin
    case (st_q)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh_q[0];
      S_XBIT:  txd = xbit_q;
      default: txd = 1'b1;
    endcase
  end

  assign empty_flag = empty_q;
  assign end_flag   = end_q;
  assign irq_empty  = irq_e_q;
  assign irq_end    = irq_t_q;

  p_txd_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(baud_tick));
  p_wr_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!empty_flag && !end_flag));
  p_end_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |-> txd);
  p_irq_end_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> (irq_end == $past(ie_end)));
  p_irq_empty_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> $past(ie_empty));
endmodule

// File: tb/serial_tx_dbuf_tb.sv
module serial_tx_dbuf_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_mark = 0;
  logic [7:0] wr_data = 0;
  logic cfg_len7 = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_mark_en = 0, cfg_stop2 = 0;
  logic ie_empty = 1, ie_end = 1, baud_tick = 0;
  logic txd, empty_flag, end_flag, irq_empty, irq_end;

  int checks = 0, fails = 0;
  int ptr = 0, ce = 0, ct = 0;
  logic log_q [0:63];

  serial_tx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mark(wr_mark),
    .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_mark_en(cfg_mark_en), .cfg_stop2(cfg_stop2), .ie_empty(ie_empty),
    .ie_end(ie_end), .baud_tick(baud_tick), .txd(txd), .empty_flag(empty_flag),
    .end_flag(end_flag), .irq_empty(irq_empty), .irq_end(irq_end));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1;
      @(negedge clk);
      baud_tick = 0;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (baud_tick) begin
        @(negedge clk);
        if (ptr < 64) log_q[ptr] = txd;
        ptr++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (irq_empty) ce++;
      if (irq_end) ct++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int build(input logic [7:0] d, input logic mk, output logic [15:0] b);
    int n = 0;
    int nd = cfg_len7 ? 7 : 8;
    int ones = 0;
    b = '0;
    b[n] = 1'b0; n++;
    for (int i = 0; i < nd; i++) begin
      b[n] = d[i]; n++;
      ones += int'(d[i]);
    end
    if (cfg_mark_en) begin b[n] = mk; n++; end
    else if (cfg_par_en) begin
      b[n] = ((ones % 2) == 1) ^ cfg_par_odd; n++;
    end
    b[n] = 1'b1; n++;
    if (cfg_stop2) begin b[n] = 1'b1; n++; end
    return n;
  endfunction

  function automatic int first_zero();
    for (int i = 0; i < 64 && i < ptr; i++) if (log_q[i] == 1'b0) return i;
    return -1;
  endfunction

  function automatic logic [15:0] grab(input int s, input int n);
    logic [15:0] v = '0;
    for (int i = 0; i < n; i++) if (s + i >= 0 && s + i < 64) v[i] = log_q[s + i];
    return v;
  endfunction

  function automatic bit tail_ones(input int from);
    for (int i = from; i < 64 && i < ptr; i++) if (log_q[i] !== 1'b1) return 0;
    return 1;
  endfunction

  task automatic wr(input logic [7:0] d, input logic mk);
    @(posedge clk);
    while (!baud_tick) @(posedge clk);
    @(negedge clk);
    wr_en = 1; wr_data = d; wr_mark = mk;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic start_log();
    @(posedge clk);
    ptr = 0; ce = 0; ct = 0;
  endtask

  task automatic single(input logic [7:0] d, input logic mk, input string req);
    logic [15:0] e;
    int n, s;
    start_log();
    n = build(d, mk, e);
    wr(d, mk);
    chk(!empty_flag && !end_flag, "R2 flags cleared by write", {empty_flag, end_flag}, 0);
    wait_ticks(16);
    s = first_zero();
    chk(s >= 0 && s < 3 && grab(s, n) == e && tail_ones(s + n) && tail_ones(0) == 0,
        req, int'(grab(s, n)), int'(e));
    chk(ce == 1 && ct == int'(ie_end), "R3/R9 interrupt pulse counts", ce * 16 + ct, 16 + int'(ie_end));
    chk(end_flag && empty_flag && txd, "R9 idle after frame", {end_flag, empty_flag, txd}, 7);
  endtask

  task automatic chained(input logic [7:0] a, input logic [7:0] b2);
    logic [15:0] ea, eb;
    int na, nb, s;
    start_log();
    na = build(a, 1'b1, ea);
    nb = build(b2, 1'b0, eb);
    wr(a, 1'b1);
    @(negedge clk);
    while (!empty_flag) @(negedge clk);
    wr(b2, 1'b0);
    wait_ticks(30);
    s = first_zero();
    chk(s >= 0 && grab(s, na) == ea, "R8 first chained frame", int'(grab(s, na)), int'(ea));
    chk(grab(s + na, nb) == eb && tail_ones(s + na + nb), "R8 second frame with no gap",
        int'(grab(s + na, nb)), int'(eb));
    chk(ce == 2 && ct == 1, "R8 one end pulse for two frames", ce * 16 + ct, 33);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && empty_flag === 1'b1 && end_flag === 1'b1, "R1 reset flags",
        {txd, empty_flag, end_flag}, 7);
    chk(irq_empty === 1'b0 && irq_end === 1'b0, "R1 reset irqs", {irq_empty, irq_end}, 0);
    rst_n = 1;
    start_log();
    wait_ticks(5);
    chk(tail_ones(0) && empty_flag && end_flag, "R1 idle without write", int'(txd), 1);

    for (int c = 0; c < 16; c++) begin
      cfg_len7    = c[0];
      cfg_stop2   = c[1];
      cfg_par_en  = (c[3:2] == 2'd1) || (c[3:2] == 2'd2);
      cfg_par_odd = (c[3:2] == 2'd2);
      cfg_mark_en = (c[3:2] == 2'd3);
      single(8'hA5, 1'b1, "R4/R5/R6/R7 frame bits");
      single(8'h3C, 1'b0, "R4/R5/R6/R7 frame bits");
      single(8'hFF, 1'b0, "R5 R7 all-ones frame");
      single(8'h01, 1'b1, "R6 R4 single-one frame");
    end

    cfg_len7 = 0; cfg_stop2 = 0; cfg_par_en = 1; cfg_par_odd = 0; cfg_mark_en = 0;
    chained(8'h5A, 8'hC3);
    cfg_len7 = 1; cfg_stop2 = 1; cfg_par_en = 0; cfg_mark_en = 1;
    chained(8'h81, 8'h7F);

    cfg_mark_en = 0; cfg_stop2 = 0; cfg_len7 = 0;
    ie_end = 0;
    single(8'h96, 1'b0, "R9 end irq gated off");
    ie_end = 1; ie_empty = 0;
    start_log();
    wr(8'h42, 1'b0);
    wait_ticks(14);
    chk(ce == 0 && ct == 1, "R3 empty irq gated off", ce * 16 + ct, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule